// File: doc/BRIEF.md
# Two-Word Instruction Fetch Sequencer

This block is the front end of a small accumulator processor. It reads a 32-bit instruction from a word-addressed memory whose data bus is 16 bits wide. The upper word holds an 8-bit opcode and the top 8 bits of a 24-bit address field. The lower word holds the remaining 16 address bits. Every memory access goes through a memory address register that is loaded from the program counter. Every returned word lands in a memory buffer register before it moves on. All state changes on the falling clock edge.

When both halves are in the instruction register, the block spends one decode cycle. If the opcode is the immediate-load code, the accumulator takes the address field during that cycle. The block then raises an instruction-valid flag toward the execute stage. It holds that flag, together with the opcode and the address field, until the execute stage reports completion. With that completion the execute stage may ask for a jump, which loads the program counter from the address field. Otherwise the program counter already points two words past the fetched instruction.

The memory is synchronous. It samples the address and the read strobe on a rising edge and returns the word before the next falling edge.

Top module: `twoword_fetch_seq`

## Requirements
- R1: Every output changes only on a falling clock edge. The outputs are constant from one rising edge until the following falling edge.
- R2: While `rst` is high at a falling edge, the following are cleared on that edge: the program counter, the instruction register (so `opcode` and `operand_addr` read zero), the accumulator and `instr_valid`. After release, the first read is from address 0.
- R3: Each instruction makes exactly two reads, each with `mem_rd` high for a single cycle. The first read is at the program counter value from when the fetch began, and the second is at that value plus one. While `mem_rd` is high, `mem_addr` equals the current program counter.
- R4: The first word read becomes instruction bits [31:16] and the second becomes bits [15:0]. `opcode` is bits [31:24] and `operand_addr` is bits [23:0].
- R5: The program counter rises by one after each word is moved into the instruction register. When `instr_valid` rises, `pc` equals the fetch start address plus 2, modulo 2^24.
- R6: Once set, `instr_valid` stays high, with `opcode` and `operand_addr` unchanged, until `ex_done` is high at a falling edge. That edge clears `instr_valid` and starts the next fetch.
- R7: If `opcode` equals the immediate code (parameter, default 8'h01), the accumulator holds the low 16 bits of the address field by the time `instr_valid` rises. Any other opcode leaves `acc` unchanged.
- R8: If `ex_jump` and `ex_done` are both high at the completing falling edge, the next fetch starts at `operand_addr`. `ex_jump` has no effect without `ex_done`.
- R9: `instr_valid` rises on the 7th falling edge after the fetch begins. The fetch begins at the first falling edge after reset release, or at the edge that consumes `ex_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 24 | Memory word address (memory address register) |
| mem_rd | output | 1 | Read strobe to the synchronous memory |
| mem_rdata | input | 16 | Word returned by the memory |
| instr_valid | output | 1 | Decoded instruction is presented to execute |
| ex_done | input | 1 | Execute stage has finished with the instruction |
| ex_jump | input | 1 | With `ex_done`, reload the program counter from the address field |
| opcode | output | 8 | Instruction register bits [31:24] |
| operand_addr | output | 24 | Instruction register bits [23:0] |
| acc | output | 16 | Accumulator |
| pc | output | 24 | Program counter |

## Verification
The assertions assume two things about the environment. First, the memory returns the addressed word before the falling edge that follows the rising edge at which `mem_rd` was seen. Second, `rst` is high at time zero. The memory model in the bench registers its read data on the rising edge only when the strobe is set. Reset is held from the start of the run. The bench changes `ex_done` and `ex_jump` just after rising edges, so that each falling edge samples settled values. In one test it drives `ex_jump` without `ex_done`, and in another it asserts reset in the middle of a fetch, so that both R8 and R2 are exercised outside the normal handshake.

// File: rtl/twf_pkg.sv
package twf_pkg;

   // Sequencer steps; the order is the fetch order.
   typedef enum logic [2:0] {
      ST_MAR_HI,
      ST_READ_HI,
      ST_IR_HI,
      ST_MAR_LO,
      ST_READ_LO,
      ST_IR_LO,
      ST_DECODE,
      ST_ISSUE
   } twf_state_t;

   // Control levels decoded from the step.
   typedef struct packed {
      logic mar_ld;
      logic mem_rd;
      logic mbr_ld;
      logic ir_hi_ld;
      logic ir_lo_ld;
      logic pc_inc;
      logic decode;
      logic issue;
   } twf_ctl_t;

   localparam int unsigned FETCH_STEPS = 7;

endpackage

// File: rtl/twf_ctrl.sv
module twf_ctrl
   import twf_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     ex_done,
   output twf_ctl_t ctl
);

   twf_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_MAR_HI:  state_d = ST_READ_HI;
         ST_READ_HI: state_d = ST_IR_HI;
         ST_IR_HI:   state_d = ST_MAR_LO;
         ST_MAR_LO:  state_d = ST_READ_LO;
         ST_READ_LO: state_d = ST_IR_LO;
         ST_IR_LO:   state_d = ST_DECODE;
         ST_DECODE:  state_d = ST_ISSUE;
         ST_ISSUE:   state_d = ex_done ? ST_MAR_HI : ST_ISSUE;
         default:    state_d = ST_MAR_HI;
      endcase
   end

   always_ff @(negedge clk) begin
      if (rst) state_q <= ST_MAR_HI;
      else     state_q <= state_d;
   end

   always_comb begin
      ctl          = '0;
      ctl.mar_ld   = (state_q == ST_MAR_HI) || (state_q == ST_MAR_LO);
      ctl.mem_rd   = (state_q == ST_READ_HI) || (state_q == ST_READ_LO);
      ctl.mbr_ld   = ctl.mem_rd;
      ctl.ir_hi_ld = (state_q == ST_IR_HI);
      ctl.ir_lo_ld = (state_q == ST_IR_LO);
      ctl.pc_inc   = ctl.ir_hi_ld || ctl.ir_lo_ld;
      ctl.decode   = (state_q == ST_DECODE);
      ctl.issue    = (state_q == ST_ISSUE);
   end

   // R3: a read strobe lasts one cycle
   a_r3_single_strobe: assert property (@(negedge clk) disable iff (rst)
      ctl.mem_rd |=> !ctl.mem_rd);

   // R6: the valid flag holds until execute completes
   a_r6_hold_valid: assert property (@(negedge clk) disable iff (rst)
      (ctl.issue && !ex_done) |=> ctl.issue);

   // R6: completion ends the issue step
   a_r6_release: assert property (@(negedge clk) disable iff (rst)
      (ctl.issue && ex_done) |=> !ctl.issue);

endmodule

// File: rtl/twf_pc.sv
module twf_pc #(
   parameter int unsigned ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              inc,
   input  logic              load,
   input  logic [ADDR_W-1:0] target,
   output logic [ADDR_W-1:0] pc
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

   always_ff @(negedge clk) begin
      if (rst)       pc <= '0;
      else if (load) pc <= target;
      else if (inc)  pc <= pc + STEP;
   end

   // R5: one step per stored word
   a_r5_pc_step: assert property (@(negedge clk) disable iff (rst)
      (inc && !load) |=> (pc == $past(pc) + STEP));

   // R8: a jump takes the target
   a_r8_pc_load: assert property (@(negedge clk) disable iff (rst)
      load |=> (pc == $past(target)));

endmodule

// File: rtl/twf_datapath.sv
module twf_datapath #(
   parameter int unsigned   DATA_W     = 16,
   parameter int unsigned   ADDR_W     = 24,
   parameter int unsigned   OPC_W      = 8,
   parameter logic [OPC_W-1:0] IMM_OPCODE = 8'h01
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     mar_ld,
   input  logic                     mbr_ld,
   input  logic                     ir_hi_ld,
   input  logic                     ir_lo_ld,
   input  logic                     decode,
   input  logic [ADDR_W-1:0]        pc,
   input  logic [DATA_W-1:0]        mem_rdata,
   output logic [ADDR_W-1:0]        mar,
   output logic [OPC_W+ADDR_W-1:0]  ir,
   output logic [DATA_W-1:0]        acc
);

   localparam int unsigned INSTR_W = OPC_W + ADDR_W;

   logic [DATA_W-1:0] mbr;
   logic [DATA_W-1:0] imm_val;
   logic              imm_hit;

   // Address side: the memory address register is fed only by the PC.
   always_ff @(negedge clk) begin
      if (rst)         mar <= '0;
      else if (mar_ld) mar <= pc;
   end

   // Data side: every returned word passes through the buffer register.
   always_ff @(negedge clk) begin
      if (rst)         mbr <= '0;
      else if (mbr_ld) mbr <= mem_rdata;
   end

   always_ff @(negedge clk) begin
      if (rst) begin
         ir <= '0;
      end else begin
         if (ir_hi_ld) ir[INSTR_W-1:DATA_W] <= mbr;
         if (ir_lo_ld) ir[DATA_W-1:0]       <= mbr;
      end
   end

   // Fit the address field to the accumulator width.
   generate
      if (ADDR_W >= DATA_W) begin : g_imm_trunc
         assign imm_val = ir[DATA_W-1:0];
      end else begin : g_imm_zext
         assign imm_val = {{(DATA_W-ADDR_W){1'b0}}, ir[ADDR_W-1:0]};
      end
   endgenerate

   assign imm_hit = decode && (ir[INSTR_W-1:ADDR_W] == IMM_OPCODE);

   always_ff @(negedge clk) begin
      if (rst)          acc <= '0;
      else if (imm_hit) acc <= imm_val;
   end

   // R4: the first half of the instruction is not touched by the second transfer
   a_r4_hi_kept: assert property (@(negedge clk) disable iff (rst)
      ir_lo_ld |=> (ir[INSTR_W-1:DATA_W] == $past(ir[INSTR_W-1:DATA_W])));

   // R7: a non-immediate decode leaves the accumulator alone
   a_r7_acc_quiet: assert property (@(negedge clk) disable iff (rst)
      !imm_hit |=> $stable(acc));

endmodule

// File: rtl/twoword_fetch_seq.sv
module twoword_fetch_seq
   import twf_pkg::*;
#(
   parameter int unsigned      DATA_W     = 16,
   parameter int unsigned      ADDR_W     = 24,
   parameter int unsigned      OPC_W      = 8,
   parameter logic [OPC_W-1:0] IMM_OPCODE = 8'h01
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              instr_valid,
   input  logic              ex_done,
   input  logic              ex_jump,
   output logic [OPC_W-1:0]  opcode,
   output logic [ADDR_W-1:0] operand_addr,
   output logic [DATA_W-1:0] acc,
   output logic [ADDR_W-1:0] pc
);

   localparam int unsigned INSTR_W = OPC_W + ADDR_W;

   generate
      if (INSTR_W != 2 * DATA_W) begin : g_bad_split
         $error("instruction must span exactly two data words");
      end
      if (OPC_W == 0 || ADDR_W == 0) begin : g_bad_fields
         $error("opcode and address fields must be non-empty");
      end
   endgenerate

   twf_ctl_t           ctl;
   logic [INSTR_W-1:0] ir;
   logic [ADDR_W-1:0]  mar;
   logic               pc_load;

   assign pc_load = ctl.issue && ex_done && ex_jump;

   twf_ctrl u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .ex_done (ex_done),
      .ctl     (ctl)
   );

   twf_pc #(.ADDR_W(ADDR_W)) u_pc (
      .clk    (clk),
      .rst    (rst),
      .inc    (ctl.pc_inc),
      .load   (pc_load),
      .target (ir[ADDR_W-1:0]),
      .pc     (pc)
   );

   twf_datapath #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .OPC_W      (OPC_W),
      .IMM_OPCODE (IMM_OPCODE)
   ) u_dp (
      .clk       (clk),
      .rst       (rst),
      .mar_ld    (ctl.mar_ld),
      .mbr_ld    (ctl.mbr_ld),
      .ir_hi_ld  (ctl.ir_hi_ld),
      .ir_lo_ld  (ctl.ir_lo_ld),
      .decode    (ctl.decode),
      .pc        (pc),
      .mem_rdata (mem_rdata),
      .mar       (mar),
      .ir        (ir),
      .acc       (acc)
   );

   assign mem_addr     = mar;
   assign mem_rd       = ctl.mem_rd;
   assign instr_valid  = ctl.issue;
   assign opcode       = ir[INSTR_W-1:ADDR_W];
   assign operand_addr = ir[ADDR_W-1:0];

   // R3: the read address is the live program counter
   a_r3_addr_from_pc: assert property (@(negedge clk) disable iff (rst)
      mem_rd |-> (mem_addr == pc));

   // R6: the presented instruction does not move while waiting
   a_r6_ir_stable: assert property (@(negedge clk) disable iff (rst)
      (instr_valid && !ex_done) |=> ($stable(opcode) && $stable(operand_addr)));

   // R7: an immediate instruction is reflected in the accumulator when issued
   a_r7_imm_loaded: assert property (@(negedge clk) disable iff (rst)
      ($rose(instr_valid) && opcode == IMM_OPCODE) |-> (acc == DATA_W'(operand_addr)));

   // R2: reset clears the program counter, accumulator and valid flag
   a_r2_reset_clear: assert property (@(negedge clk)
      rst |=> (pc == '0 && acc == '0 && !instr_valid));

endmodule

// File: tb/twoword_fetch_seq_bench.sv
`timescale 1ns/1ps
module twoword_fetch_seq_bench;

   localparam logic [7:0] IMM = 8'h01;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [23:0] mem_addr;
   logic        mem_rd;
   logic [15:0] mem_rdata = '0;
   logic        instr_valid;
   logic        ex_done = 1'b0;
   logic        ex_jump = 1'b0;
   logic [7:0]  opcode;
   logic [23:0] operand_addr;
   logic [15:0] acc;
   logic [23:0] pc;

   always #2.5 clk = ~clk;

   twoword_fetch_seq u_twoword_fetch_seq (
      .clk, .rst, .mem_addr, .mem_rd, .mem_rdata, .instr_valid,
      .ex_done, .ex_jump, .opcode, .operand_addr, .acc, .pc
   );

   // Synchronous memory model: 256 words, low address bits index it.
   logic [15:0] mem [256];
   always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

   typedef struct {
      logic [23:0] pc0;
      logic [7:0]  opc;
      logic [23:0] addr;
      logic [15:0] acc;
   } exp_t;

   exp_t        exp_q[$];
   logic [23:0] reads[$];
   int          n_chk = 0;
   int          n_bad = 0;
   logic [23:0] m_pc  = '0;
   logic [15:0] m_acc = '0;
   bit          seen  = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   // Monitor: pop one expectation per issued instruction.
   always @(posedge clk) begin
      if (rst) begin
         reads.delete();
         seen = 1'b0;
      end else begin
         if (mem_rd) reads.push_back(mem_addr);
         if (instr_valid && !seen) begin
            exp_t e;
            seen = 1'b1;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R6", "unexpected issue", 32'(opcode), 32'(0));
            end else begin
               e = exp_q.pop_front();
               chk(opcode == e.opc, "R4", "opcode", 32'(opcode), 32'(e.opc));
               chk(operand_addr == e.addr, "R4", "address field", 32'(operand_addr), 32'(e.addr));
               chk(acc == e.acc, "R7", "accumulator", 32'(acc), 32'(e.acc));
               chk(pc == e.pc0 + 24'd2, "R5", "pc after fetch", 32'(pc), 32'(e.pc0 + 24'd2));
               chk(reads.size() == 2, "R3", "read count", 32'(reads.size()), 32'(2));
               if (reads.size() == 2) begin
                  chk(reads[0] == e.pc0, "R3", "first read addr", 32'(reads[0]), 32'(e.pc0));
                  chk(reads[1] == e.pc0 + 24'd1, "R3", "second read addr", 32'(reads[1]), 32'(e.pc0 + 24'd1));
               end
            end
            reads.delete();
         end
         if (!instr_valid) seen = 1'b0;
      end
   end

   // R1: nothing moves between a rising edge and the next falling edge.
   always @(posedge clk) begin
      logic [23:0] s_pc, s_addr;
      logic        s_v, s_rd;
      s_pc = pc; s_addr = mem_addr; s_v = instr_valid; s_rd = mem_rd;
      #1.5;
      chk(pc == s_pc && mem_addr == s_addr && instr_valid == s_v && mem_rd == s_rd,
          "R1", "outputs moved off the falling edge", 32'(pc), 32'(s_pc));
   end

   // Driver: predict the instruction, push it, run the handshake.
   task automatic issue(input bit jump, input int hold, input bit stray);
      exp_t        e;
      logic [15:0] hi, lo;
      int          lat;
      hi     = mem[m_pc[7:0]];
      lo     = mem[8'(m_pc + 24'd1)];
      e.pc0  = m_pc;
      e.opc  = hi[15:8];
      e.addr = {hi[7:0], lo};
      if (e.opc == IMM) m_acc = lo;
      e.acc  = m_acc;
      exp_q.push_back(e);
      lat = 0;
      do begin
         @(posedge clk);
         lat++;
      end while (!instr_valid && lat < 50);
      chk(lat == 7, "R9", "issue latency", 32'(lat), 32'(7));
      for (int i = 0; i < hold; i++) begin
         #1 ex_jump = stray;
         @(posedge clk);
         chk(instr_valid == 1'b1, "R6", "valid held", 32'(instr_valid), 32'(1));
         chk(opcode == e.opc, "R6", "opcode held", 32'(opcode), 32'(e.opc));
      end
      #1 ex_done = 1'b1; ex_jump = jump;
      @(posedge clk);
      chk(instr_valid == 1'b0, "R6", "valid cleared", 32'(instr_valid), 32'(0));
      #1 ex_done = 1'b0; ex_jump = 1'b0;
      m_pc = jump ? e.addr : e.pc0 + 24'd2;
   endtask

   task automatic check_reset_state();
      chk(pc == '0, "R2", "pc in reset", 32'(pc), 32'(0));
      chk(acc == '0, "R2", "acc in reset", 32'(acc), 32'(0));
      chk(instr_valid == 1'b0, "R2", "valid in reset", 32'(instr_valid), 32'(0));
      chk(opcode == '0 && operand_addr == '0, "R2", "ir in reset", 32'({opcode, operand_addr}), 32'(0));
   endtask

   initial begin
      for (int k = 0; k < 256; k++) mem[k] = 16'((k * 40503 + 7) ^ (k << 9));
      mem[0]    = 16'h01AB; mem[1]    = 16'hCDEF;   // immediate, acc <- CDEF
      mem[2]    = 16'h7712; mem[3]    = 16'h3456;   // not immediate, acc kept
      mem[4]    = 16'h0100; mem[5]    = 16'h0000;   // immediate zero
      mem[6]    = 16'h01FF; mem[7]    = 16'hFFFF;   // immediate all ones
      mem[8]    = 16'h4000; mem[9]    = 16'h0040;   // jump target 0x000040
      mem[8'h40] = 16'h9CFF; mem[8'h41] = 16'hFFFE; // jump target 0xFFFFFE
      mem[8'hFE] = 16'h0112; mem[8'hFF] = 16'h2345; // immediate at top, pc wraps

      repeat (3) @(posedge clk);
      check_reset_state();
      #1 rst = 1'b0;

      issue(1'b0, 0, 1'b0);
      issue(1'b0, 2, 1'b0);
      issue(1'b0, 0, 1'b0);
      issue(1'b0, 1, 1'b0);
      issue(1'b1, 1, 1'b0);          // R8 jump to 0x40
      issue(1'b1, 3, 1'b0);          // R8 jump to 0xFFFFFE
      issue(1'b0, 3, 1'b1);          // R8 stray jump ignored, R5 wrap to 0
      issue(1'b0, 0, 1'b0);
      issue(1'b0, 4, 1'b1);
      issue(1'b0, 0, 1'b0);

      // R2: reset in the middle of a fetch
      @(posedge clk);
      @(posedge clk);
      #1 rst = 1'b1;
      repeat (2) @(posedge clk);
      check_reset_state();
      exp_q.delete();
      m_pc  = '0;
      m_acc = '0;
      #1 rst = 1'b0;
      issue(1'b0, 0, 1'b0);
      issue(1'b0, 1, 1'b0);
      issue(1'b1, 0, 1'b0);

      @(posedge clk);
      chk(exp_q.size() == 0, "R6", "expectations left over", 32'(exp_q.size()), 32'(0));
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog expired actual=%h expected=%h", 32'(0), 32'(1));
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule